// File: doc/BRIEF.md
# MSI Event Queue Controller

The block takes posted MSI writes, each an address offset from the MSI window base plus a 16-bit data value, and files them into up to six event rings kept in host memory. Each ring holds 64 word entries. The offset of the write selects the ring. The block builds the 32-bit entry and writes it through a single-outstanding memory-write port. Once that write is acknowledged, the ring's tail pointer moves forward. After the tail has moved, the ring's level interrupt comes up. Software drains the ring by reading entries from host memory and then writing the ring's head register.

Two parameters choose the layout. With `PER_QUEUE_PAGE=1`, every ring has its own 4 KB page above the ring base and its own 4 KB window above the MSI base. With `PER_QUEUE_PAGE=0`, all rings share one page at 256-byte strides and are selected by word offset. `HAS_INTEN` adds a per-ring interrupt mask register that applies on top of the control bits.

Register map (byte addresses on `reg_addr`): 0x00 ring base low, 0x04 ring base high, 0x08 interrupt mask (bit n = ring n), 0x0C overflow flags (write 1 to clear), 0x10+4n control, 0x30+4n head, 0x50+4n tail (read-only), 0x70+4n pending count (read-only).

Top module: `msi_evq_ctrl`

## Requirements
- R1: After reset every head, tail and pending count reads 0, every `irq` bit is 0, `mem_req` is 0 and `msi_ready` is 1.
- R2: With `PER_QUEUE_PAGE=1`, an MSI write at offset q×4096 (plus any offset within that window) goes to ring q. A write is dropped with no memory write and no tail change if q ≥ `NUM_Q` or if control bit 0 of ring q is clear.
- R3: The entry written is {16'h0000, data}. Its address is base + q×4096 + tail×4, where base is the 64-bit value {reg 0x04, reg 0x00}.
- R4: `mem_req`, `mem_addr` and `mem_wdata` stay constant until `mem_ack`. The tail advances on the edge that samples `mem_ack`. The ring's `irq` rises no earlier than one clock after that edge. `msi_ready` is 0 while a write is in flight.
- R5: The tail wraps from 63 to 0. A head write keeps only bits [5:0]. Writes to the tail register have no effect.
- R6: The pending count register of ring n reads (tail − head) mod 64. This is 64 − (head − tail) when tail < head and tail − head otherwise.
- R7: If ring q is full (tail+1 ≡ head mod 64), an arriving event is dropped, the tail stays put and bit q of the overflow register becomes 1. The bit stays 1 until software writes 1 to that bit.
- R8: `irq[n]` is a registered level. It is 1 while ring n is fully enabled and head ≠ tail, and it falls one clock after the head write that makes head equal tail.
- R9: With `HAS_INTEN=1`, clearing bit n of the mask register forces `irq[n]` to 0 and setting it restores the level.
- R10: Control bits are bit 0 ring enable, bit 1 interrupt on event and bit 11 interrupt output enable. `irq[n]` needs all three. A ring with bit 0 set still accepts events when bit 1 or bit 11 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msi_valid | input | 1 | An MSI write is offered |
| msi_ready | output | 1 | Block can take an MSI write this cycle |
| msi_off | input | OFF_W | Byte offset of the MSI write from the MSI base |
| msi_data | input | 16 | MSI data value |
| mem_req | output | 1 | Entry write to host memory pending |
| mem_addr | output | ADDR_W | Byte address of the entry |
| mem_wdata | output | 32 | Entry word |
| mem_ack | input | 1 | Memory accepted the entry write |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| irq | output | NUM_Q | Per-ring interrupt level |

## Verification
A corrupted tail shows up on the entry address of the very next event and on the tail and count registers one read later. A wrong head shows up in the count and also as an interrupt that does not fall, one clock after the head write. An ordering fault, such as the tail moving or the interrupt rising before the acknowledge, shows up in the cycle right after the acknowledge edge, where the interrupt must still hold its old value. Overflow faults show up on the first event offered to a full ring, as a spurious memory request or a missing sticky flag.

// File: rtl/msi_evq_pkg.sv
package msi_evq_pkg;
    localparam int PTR_W      = 6;
    localparam int RING_SLOTS = 1 << PTR_W;
    localparam int PAGE_SHIFT = 12;
    localparam int RING_SHIFT = PTR_W + 2;

    localparam int CB_ENABLE = 0;
    localparam int CB_EVTINT = 1;
    localparam int CB_IRQOUT = 11;

    localparam int RA_BASE_LO = 'h00;
    localparam int RA_BASE_HI = 'h04;
    localparam int RA_MASK    = 'h08;
    localparam int RA_OVF     = 'h0C;
    localparam int RA_CTRL0   = 'h10;
    localparam int RA_HEAD0   = 'h30;
    localparam int RA_TAIL0   = 'h50;
    localparam int RA_CNT0    = 'h70;

    typedef enum logic {ST_IDLE, ST_WRITE} wr_state_e;
endpackage

// File: rtl/msi_evq_decode.sv
module msi_evq_decode #(
    parameter int NUM_Q          = 6,
    parameter int OFF_W          = 16,
    parameter int PER_QUEUE_PAGE = 1,
    localparam int QW            = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic [OFF_W-1:0] off,
    output logic [QW-1:0]    qsel,
    output logic             hit
);
    import msi_evq_pkg::*;

    logic [31:0] q_full;

    generate
        if (PER_QUEUE_PAGE != 0) begin : g_page
            always_comb begin
                q_full = 32'(off >> PAGE_SHIFT);
                hit    = (q_full < 32'(NUM_Q));
            end
        end else begin : g_word
            always_comb begin
                q_full = 32'(off >> 2);
                hit    = (q_full < 32'(NUM_Q)) && (off[1:0] == 2'b00);
            end
        end
    endgenerate

    assign qsel = q_full[QW-1:0];
endmodule

// File: rtl/msi_evq_irq.sv
module msi_evq_irq #(
    parameter int NUM_Q     = 6,
    parameter int HAS_INTEN = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_Q-1:0] ctrl_ok,
    input  logic [NUM_Q-1:0] mask,
    input  logic [NUM_Q-1:0] nonempty,
    output logic [NUM_Q-1:0] irq
);
    logic [NUM_Q-1:0] lvl_d, lvl_q;

    generate
        if (HAS_INTEN != 0) begin : g_mask
            always_comb lvl_d = ctrl_ok & mask & nonempty;
        end else begin : g_nomask
            always_comb lvl_d = ctrl_ok & nonempty;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    assign irq = lvl_q;

    logic unused_mask;
    assign unused_mask = (HAS_INTEN == 0) ? ^mask : 1'b0;
endmodule

// File: rtl/msi_evq_ctrl.sv
module msi_evq_ctrl #(
    parameter int NUM_Q          = 6,
    parameter int OFF_W          = 16,
    parameter int ADDR_W         = 64,
    parameter int PER_QUEUE_PAGE = 1,
    parameter int HAS_INTEN      = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msi_valid,
    output logic              msi_ready,
    input  logic [OFF_W-1:0]  msi_off,
    input  logic [15:0]       msi_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NUM_Q-1:0]  irq
);
    import msi_evq_pkg::*;

    localparam int QW      = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
    localparam int Q_SHIFT = (PER_QUEUE_PAGE != 0) ? PAGE_SHIFT : RING_SHIFT;

    typedef struct packed {
        wr_state_e                    st;
        logic [NUM_Q-1:0][PTR_W-1:0]  head;
        logic [NUM_Q-1:0][PTR_W-1:0]  tail;
        logic [NUM_Q-1:0][2:0]        ctrl;
        logic [NUM_Q-1:0]             mask;
        logic [NUM_Q-1:0]             ovf;
        logic [ADDR_W-1:0]            base;
        logic [QW-1:0]                cur_q;
        logic [ADDR_W-1:0]            addr;
        logic [15:0]                  data;
    } evq_state_t;

    evq_state_t st_d, st_q;

    logic [QW-1:0]    dec_q;
    logic             dec_hit;
    logic [NUM_Q-1:0] ctrl_ok, nonempty;

    msi_evq_decode #(
        .NUM_Q(NUM_Q), .OFF_W(OFF_W), .PER_QUEUE_PAGE(PER_QUEUE_PAGE)
    ) i_decode (
        .off(msi_off), .qsel(dec_q), .hit(dec_hit)
    );

    always_comb begin
        for (int i = 0; i < NUM_Q; i++) begin
            ctrl_ok[i]  = &st_q.ctrl[i];
            nonempty[i] = (st_q.head[i] != st_q.tail[i]);
        end
    end

    msi_evq_irq #(.NUM_Q(NUM_Q), .HAS_INTEN(HAS_INTEN)) i_irq (
        .clk(clk), .rst_n(rst_n), .ctrl_ok(ctrl_ok),
        .mask(st_q.mask), .nonempty(nonempty), .irq(irq)
    );

    always_comb begin
        logic [PTR_W-1:0] nxt_tail;
        st_d     = st_q;
        nxt_tail = st_q.tail[dec_q] + PTR_W'(1);

        if (reg_we) begin
            case (32'(reg_addr))
                RA_BASE_LO: st_d.base[31:0]        = reg_wdata;
                RA_BASE_HI: st_d.base[ADDR_W-1:32] = reg_wdata[ADDR_W-33:0];
                RA_MASK:    st_d.mask              = reg_wdata[NUM_Q-1:0];
                RA_OVF:     st_d.ovf               = st_q.ovf & ~reg_wdata[NUM_Q-1:0];
                default: ;
            endcase
            for (int i = 0; i < NUM_Q; i++) begin
                if (32'(reg_addr) == RA_CTRL0 + 4*i)
                    st_d.ctrl[i] = {reg_wdata[CB_IRQOUT], reg_wdata[CB_EVTINT], reg_wdata[CB_ENABLE]};
                if (32'(reg_addr) == RA_HEAD0 + 4*i)
                    st_d.head[i] = reg_wdata[PTR_W-1:0];
            end
        end

        case (st_q.st)
            ST_IDLE: begin
                if (msi_valid && dec_hit && st_q.ctrl[dec_q][0]) begin
                    if (nxt_tail == st_q.head[dec_q]) begin
                        st_d.ovf[dec_q] = 1'b1;
                    end else begin
                        st_d.st    = ST_WRITE;
                        st_d.cur_q = dec_q;
                        st_d.data  = msi_data;
                        st_d.addr  = st_q.base
                                   + (ADDR_W'(dec_q) << Q_SHIFT)
                                   + (ADDR_W'(st_q.tail[dec_q]) << 2);
                    end
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    st_d.tail[st_q.cur_q] = st_q.tail[st_q.cur_q] + PTR_W'(1);
                    st_d.st               = ST_IDLE;
                end
            end
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (32'(reg_addr))
            RA_BASE_LO: reg_rdata = st_q.base[31:0];
            RA_BASE_HI: reg_rdata = 32'(st_q.base[ADDR_W-1:32]);
            RA_MASK:    reg_rdata = 32'(st_q.mask);
            RA_OVF:     reg_rdata = 32'(st_q.ovf);
            default: ;
        endcase
        for (int i = 0; i < NUM_Q; i++) begin
            if (32'(reg_addr) == RA_CTRL0 + 4*i) begin
                reg_rdata[CB_ENABLE] = st_q.ctrl[i][0];
                reg_rdata[CB_EVTINT] = st_q.ctrl[i][1];
                reg_rdata[CB_IRQOUT] = st_q.ctrl[i][2];
            end
            if (32'(reg_addr) == RA_HEAD0 + 4*i) reg_rdata = 32'(st_q.head[i]);
            if (32'(reg_addr) == RA_TAIL0 + 4*i) reg_rdata = 32'(st_q.tail[i]);
            if (32'(reg_addr) == RA_CNT0 + 4*i)
                reg_rdata = 32'(PTR_W'(st_q.tail[i] - st_q.head[i]));
        end
    end

    assign msi_ready = (st_q.st == ST_IDLE);
    assign mem_req   = (st_q.st == ST_WRITE);
    assign mem_addr  = st_q.addr;
    assign mem_wdata = {16'h0000, st_q.data};
endmodule

// File: rtl/msi_evq_chk.sv
module msi_evq_chk #(
    parameter int NUM_Q  = 6,
    parameter int ADDR_W = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                msi_ready,
    input logic                mem_req,
    input logic                mem_ack,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [31:0]         mem_wdata,
    input logic [NUM_Q-1:0]    irq,
    input logic [NUM_Q*6-1:0]  tail_flat,
    input logic [NUM_Q*6-1:0]  head_flat
);
    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req);

    // R4
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> $stable(mem_addr) && $stable(mem_wdata));

    // R4
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !msi_ready);

    // R4
    tail_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tail_flat) |-> $past(mem_req && mem_ack));

    // R3
    entry_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_wdata[31:16] == 16'h0000));

    genvar g;
    generate
        for (g = 0; g < NUM_Q; g++) begin : g_q
            // R8
            irq_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
                irq[g] |-> $past(head_flat[g*6 +: 6] != tail_flat[g*6 +: 6]));
        end
    endgenerate
endmodule

bind msi_evq_ctrl msi_evq_chk #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .msi_ready(msi_ready), .mem_req(mem_req),
    .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq),
    .tail_flat(st_q.tail), .head_flat(st_q.head)
);

// File: tb/test_msi_evq_ctrl.sv
module test_msi_evq_ctrl;
    localparam int NQ = 6;
    localparam logic [63:0] BASE = 64'h0000_0012_3456_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msi_valid = 1'b0;
    logic        msi_ready;
    logic [15:0] msi_off = '0;
    logic [15:0] msi_data = '0;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NQ-1:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int tail_m [NQ];
    int head_m [NQ];

    always #10 clk = ~clk;

    msi_evq_ctrl i_msi_evq_ctrl (
        .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_ready(msi_ready),
        .msi_off(msi_off), .msi_data(msi_data), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // {queue[31:24], ack delay[23:16], data[15:0]}
    localparam logic [31:0] VEC [8] = '{
        32'h00_00_A5A5, 32'h01_02_1234, 32'h05_01_BEEF, 32'h02_03_0F0F,
        32'h01_00_7777, 32'h00_04_FFFF, 32'h03_01_0001, 32'h04_00_8001
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input int a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'(a); reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input int a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = 8'(a);
        #1 v = reg_rdata;
    endtask

    task automatic send(input int q, input logic [15:0] d, input int dly, input bit expect_wr);
        @(negedge clk);
        msi_valid = 1'b1; msi_off = 16'(q * 4096); msi_data = d;
        @(negedge clk);
        msi_valid = 1'b0;
        if (expect_wr) begin
            chk("R3 addr", mem_addr, BASE + 64'(q * 4096) + 64'(tail_m[q] * 4));
            chk("R3 data", {32'h0, mem_wdata}, {48'h0, d});
            chk("R4 ready low", {63'h0, msi_ready}, 64'h0);
            for (int k = 0; k < dly; k++) begin
                chk("R4 req held", {63'h0, mem_req}, 64'h1);
                @(negedge clk);
            end
            chk("R4 req before ack", {63'h0, mem_req}, 64'h1);
            mem_ack = 1'b1;
            @(negedge clk);
            mem_ack = 1'b0;
            chk("R4 req drops", {63'h0, mem_req}, 64'h0);
            tail_m[q] = (tail_m[q] + 1) % 64;
        end else begin
            for (int k = 0; k < 3; k++) begin
                chk("R2 no write", {63'h0, mem_req}, 64'h0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic prev;
        for (int i = 0; i < NQ; i++) begin tail_m[i] = 0; head_m[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", 64'(irq), 64'h0);
        chk("R1 mem_req", {63'h0, mem_req}, 64'h0);
        chk("R1 ready", {63'h0, msi_ready}, 64'h1);
        reg_rd('h50, v); chk("R1 tail", 64'(v), 64'h0);
        reg_rd('h74, v); chk("R1 count", 64'(v), 64'h0);
        reg_rd('h30, v); chk("R1 head", 64'(v), 64'h0);

        reg_wr('h00, BASE[31:0]);
        reg_wr('h04, BASE[63:32]);
        reg_wr('h08, 32'h3F);
        for (int i = 0; i < NQ; i++) reg_wr('h10 + 4*i, 32'h803);

        // R2 R3 R4 R8 vector walk
        for (int n = 0; n < 8; n++) begin
            int q;
            q = int'(VEC[n][31:24]);
            prev = (tail_m[q] != head_m[q]);
            send(q, VEC[n][15:0], int'(VEC[n][23:16]), 1'b1);
            chk("R4 irq not before tail", {63'h0, irq[q]}, {63'h0, prev});
            @(negedge clk);
            chk("R8 irq high", {63'h0, irq[q]}, 64'h1);
            reg_rd('h50 + 4*q, v); chk("R2 tail", 64'(v), 64'(tail_m[q]));
        end

        // R6 counts and R8 fall on head write
        reg_rd('h70, v); chk("R6 count q0", 64'(v), 64'd2);
        reg_rd('h74, v); chk("R6 count q1", 64'(v), 64'd2);
        reg_wr('h30, 32'd1); head_m[0] = 1;
        reg_rd('h70, v); chk("R6 count after head", 64'(v), 64'd1);
        chk("R8 irq still high", {63'h0, irq[0]}, 64'h1);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'h30; reg_wdata = 32'd2;
        @(negedge clk);
        reg_we = 1'b0; head_m[0] = 2;
        chk("R8 irq one clock late", {63'h0, irq[0]}, 64'h1);
        @(negedge clk);
        chk("R8 irq falls", {63'h0, irq[0]}, 64'h0);

        // R5 tail write ignored
        reg_wr('h54, 32'd5);
        reg_rd('h54, v); chk("R5 tail read-only", 64'(v), 64'd2);

        // R10 control gating, R2 disabled drop
        reg_wr('h18, 32'h0);
        @(negedge clk);
        chk("R10 irq off when disabled", {63'h0, irq[2]}, 64'h0);
        send(2, 16'h5555, 0, 1'b0);
        reg_rd('h58, v); chk("R2 disabled tail", 64'(v), 64'd1);
        reg_wr('h18, 32'h003);
        @(negedge clk);
        chk("R10 irq needs bit 11", {63'h0, irq[2]}, 64'h0);
        send(2, 16'h6666, 1, 1'b1);
        reg_rd('h58, v); chk("R10 accepts without irq bits", 64'(v), 64'd2);
        reg_wr('h18, 32'h801);
        @(negedge clk);
        chk("R10 irq needs bit 1", {63'h0, irq[2]}, 64'h0);
        reg_wr('h18, 32'h803);
        @(negedge clk);
        chk("R10 irq with all bits", {63'h0, irq[2]}, 64'h1);

        // R9 mask gating
        reg_wr('h08, 32'h37);
        @(negedge clk);
        chk("R9 masked", {63'h0, irq[3]}, 64'h0);
        reg_wr('h08, 32'h3F);
        @(negedge clk);
        chk("R9 unmasked", {63'h0, irq[3]}, 64'h1);

        // R2 out-of-range ring
        send(6, 16'h9999, 0, 1'b0);

        // R7 fill ring 4 then overflow
        for (int k = 0; k < 62; k++) send(4, 16'(k), 0, 1'b1);
        reg_rd('h70 + 16, v); chk("R6 count full", 64'(v), 64'd63);
        send(4, 16'hDEAD, 0, 1'b0);
        reg_rd('h60, v); chk("R7 tail held", 64'(v), 64'd63);
        reg_rd('h0C, v); chk("R7 overflow set", 64'(v), 64'h10);
        reg_wr('h0C, 32'h0);
        reg_rd('h0C, v); chk("R7 overflow sticky", 64'(v), 64'h10);
        reg_wr('h0C, 32'h10);
        reg_rd('h0C, v); chk("R7 overflow cleared", 64'(v), 64'h0);

        // R5 wrap and head masking
        reg_wr('h40, 32'd63); head_m[4] = 63;
        send(4, 16'hC0DE, 0, 1'b1);
        reg_rd('h60, v); chk("R5 tail wraps", 64'(v), 64'd0);
        reg_rd('h80, v); chk("R6 count across wrap", 64'(v), 64'd1);
        reg_wr('h40, 32'hFFC0);
        reg_rd('h40, v); chk("R5 head low bits", 64'(v), 64'd0);
        reg_rd('h80, v); chk("R6 count zero", 64'(v), 64'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule